// File: doc/BRIEF.md
# SAR ADC Acquisition and Conversion Sequencer

This block is the digital control sequencer for a 10-bit successive-approximation converter. Software starts a cycle by writing a start request, and the block reports that cycle through a busy status. While idle, the sample switch stays closed on whichever input the channel field selects. A 3-bit acquisition code decides what happens after the start request. A zero code means manual acquisition: sampling stops at once and bit decisions begin. Any other code keeps the switch closed for a set number of conversion-clock (TAD) periods, and conversion then starts with no further action from software.

Conversion makes one bit decision on each TAD enable, most significant bit first. Each decision is driven by a comparator answer to the trial code the block presents. When the last decision is made, the result is captured in the chosen justification. In that same cycle busy drops, a sticky interrupt flag is raised and sampling resumes. The channel and reference selects are decoded straight through to the analog muxes. The sample-hold, the DAC and the comparator sit outside the block.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, go_busy = 0, irq_flag = 0, result = 0, sample_en = 1 and trial_code = 0.
- R2: With acq_sel = 0, an accepted go_set makes go_busy = 1 and sample_en = 0 from the next cycle on. No TAD periods of acquisition are spent.
- R3: With acq_sel = 1..7, an accepted go_set keeps sample_en = 1 and go_busy = 1 for exactly 2, 4, 6, 8, 12, 16 or 20 TAD enables. Conversion then starts by itself.
- R4: Conversion takes exactly 10 TAD enables, most significant bit first. The first trial_code is 0x200. At each enable the trial bit is kept when cmp_in = 1 and cleared otherwise.
- R5: In the cycle after the last bit decision, go_busy = 0, irq_flag = 1 and sample_en = 1.
- R6: irq_flag stays at 1 until an irq_clr pulse clears it. A completion in the same cycle as irq_clr leaves it at 1.
- R7: A go_set while go_busy = 1 is ignored. The cycle in progress keeps its timing and its result.
- R8: result changes only at the end of a conversion. If left_just = 1 at that moment, result[15:6] holds the code and result[5:0] = 0. Otherwise result[9:0] holds the code and result[15:10] = 0.
- R9: chan_mux equals chan_sel at all times, whether idle, acquiring or converting.
- R10: pref_mux is one-hot. Bit 0 selects the supply, bit 1 the external pin and bit 2 the fixed internal reference. It decodes pref_sel as 00 to bit 0, 01 to bit 1, 10 to bit 2 and 11 to bit 0. nref_mux bit 0 selects ground and bit 1 the external pin; it decodes nref_sel 01 to bit 1 and every other value to bit 0.
- R11: go_busy stays high without a break from the accepted go_set to the end of conversion. No output marks the change from acquisition to conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tad_en | input | 1 | One-cycle enable per conversion-clock period |
| go_set | input | 1 | Software start request pulse |
| irq_clr | input | 1 | Software clear pulse for the interrupt flag |
| acq_sel | input | 3 | Acquisition-time code, 0 = manual |
| chan_sel | input | 5 | Analog channel select |
| pref_sel | input | 2 | Positive reference select |
| nref_sel | input | 2 | Negative reference select |
| left_just | input | 1 | Result justification, 1 = left |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial level |
| sample_en | output | 1 | Sample switch closed |
| chan_mux | output | 5 | Channel mux select |
| pref_mux | output | 3 | One-hot positive reference select |
| nref_mux | output | 2 | One-hot negative reference select |
| trial_code | output | 10 | SAR trial code for the DAC |
| result | output | 16 | Justified conversion result |
| go_busy | output | 1 | Start/busy status |
| irq_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The hardest case to reach from the ports is a second start request that arrives partway through a cycle. If it were wrongly accepted, it would restart acquisition with a different acquisition code, and busy would never show the restart. The stimulus sweeps all eight acquisition codes against a spread of analog levels and three TAD cadences. Some of these runs inject a go_set carrying acq_sel = 7 in the middle of a cycle. The bench then counts the TAD enables spent in each phase, which shows that neither phase length nor the result was disturbed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_ACQ, PH_CONV} phase_t;

  // Acquisition length in TAD periods: 2 per step up to code 4, 4 per step above.
  function automatic logic [4:0] acq_tad_count(input logic [2:0] code);
    logic [4:0] c;
    c = {2'b00, code};
    if (code <= 3'd4) return c << 1;
    else              return (c << 2) - 5'd8;
  endfunction

  // Positive reference: 01 external pin, 10 fixed internal, else supply.
  function automatic logic [2:0] pos_ref_decode(input logic [1:0] s);
    case (s)
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  // Negative reference: 01 external pin, else ground.
  function automatic logic [1:0] neg_ref_decode(input logic [1:0] s);
    return (s == 2'b01) ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
  parameter int CNT_W   = 5,
  parameter int MAX_TAD = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tad_en,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             running;

  assign running = (cnt_q != '0);
  assign expire  = running && tad_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (running && tad_en) cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_acq_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_TAD));
  assert_acq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tad_en && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tad_en,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] decided_code,
  output logic             last_dec
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] mask;
  logic             dec;

  assign mask         = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
  assign trial        = active_q ? (sar_q | mask) : '0;
  assign dec          = active_q && tad_en;
  assign last_dec     = dec && (idx_q == '0);
  assign decided_code = cmp_in ? (sar_q | mask) : sar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sar_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= IDX_W'(RES_W-1);
      sar_q    <= '0;
    end else if (dec) begin
      sar_q <= decided_code;
      if (idx_q == '0) active_q <= 1'b0;
      else             idx_q    <= idx_q - IDX_W'(1);
    end
  end

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial == (RES_W'(1) << (RES_W-1))));
  assert_bit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !last_dec && !start) |=> (idx_q == $past(idx_q) - IDX_W'(1)));

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] code,
  input  logic             left_just,
  output logic [OUT_W-1:0] result
);
  localparam int PAD_W = OUT_W - RES_W;

  function automatic logic [OUT_W-1:0] justify(input logic [RES_W-1:0] c, input logic left);
    return left ? {c, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, c};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (capture) result <= justify(code, left_just);
  end

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16,
  parameter int CH_W  = 5,
  parameter int ACQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tad_en,
  input  logic             go_set,
  input  logic             irq_clr,
  input  logic [2:0]       acq_sel,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       pref_sel,
  input  logic [1:0]       nref_sel,
  input  logic             left_just,
  input  logic             cmp_in,
  output logic             sample_en,
  output logic [CH_W-1:0]  chan_mux,
  output logic [2:0]       pref_mux,
  output logic [1:0]       nref_mux,
  output logic [RES_W-1:0] trial_code,
  output logic [OUT_W-1:0] result,
  output logic             go_busy,
  output logic             irq_flag
);
  import adc_seq_pkg::*;

  phase_t           phase_q, phase_d;
  logic             go_accept, manual, acq_expire, sar_start, conv_done;
  logic [RES_W-1:0] decided_code;
  logic             irq_q;

  assign manual    = (acq_sel == 3'd0);
  assign go_accept = go_set && (phase_q == PH_IDLE);
  assign sar_start = (go_accept && manual) || acq_expire;

  adc_acq_timer #(.CNT_W(ACQ_W), .MAX_TAD(20)) u_acq (
    .clk(clk), .rst_n(rst_n),
    .load(go_accept && !manual),
    .load_val(ACQ_W'(acq_tad_count(acq_sel))),
    .tad_en(tad_en), .expire(acq_expire)
  );

  adc_sar_engine #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(sar_start), .tad_en(tad_en),
    .cmp_in(cmp_in), .trial(trial_code), .decided_code(decided_code),
    .last_dec(conv_done)
  );

  adc_result_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .capture(conv_done), .code(decided_code),
    .left_just(left_just), .result(result)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (go_accept) phase_d = manual ? PH_CONV : PH_ACQ;
      PH_ACQ:  if (acq_expire) phase_d = PH_CONV;
      PH_CONV: if (conv_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (conv_done)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign go_busy   = (phase_q != PH_IDLE);
  assign sample_en = (phase_q != PH_CONV);
  assign irq_flag  = irq_q;
  assign chan_mux  = chan_sel;
  assign pref_mux  = pos_ref_decode(pref_sel);
  assign nref_mux  = neg_ref_decode(nref_sel);

  assert_manual_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_busy && go_set && acq_sel == 3'd0) |=> (go_busy && !sample_en));
  assert_auto_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_busy && go_set && acq_sel != 3'd0) |=> (go_busy && sample_en));
  assert_done_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_busy) |-> (irq_flag && sample_en));
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (go_busy && !conv_done) |=> go_busy);
  assert_ignore_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && go_set && !conv_done) |=> (phase_q == PH_CONV));
  assert_ref_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pref_mux) && $onehot(nref_mux));

endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tad_en = 1'b0, go_set = 1'b0, irq_clr = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic [4:0] chan_sel = 5'd0;
  logic [1:0] pref_sel = 2'd0, nref_sel = 2'd0;
  logic       left_just = 1'b0, cmp_in;
  logic       sample_en, go_busy, irq_flag;
  logic [4:0] chan_mux;
  logic [2:0] pref_mux;
  logic [1:0] nref_mux;
  logic [9:0] trial_code, vin = 10'd0;
  logic [15:0] result;

  int checks = 0, fails = 0, tick = 0;

  always #2.5 clk = ~clk;

  // Comparator model: high when the analog level is at or above the DAC trial.
  assign cmp_in = (vin >= trial_code);

  adc_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .tad_en(tad_en), .go_set(go_set), .irq_clr(irq_clr),
    .acq_sel(acq_sel), .chan_sel(chan_sel), .pref_sel(pref_sel), .nref_sel(nref_sel),
    .left_just(left_just), .cmp_in(cmp_in), .sample_en(sample_en), .chan_mux(chan_mux),
    .pref_mux(pref_mux), .nref_mux(nref_mux), .trial_code(trial_code), .result(result),
    .go_busy(go_busy), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int acq_expect(input int code);
    case (code)
      0: return 0;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 12;  6: return 16;  default: return 20;
    endcase
  endfunction

  function automatic logic [15:0] fmt_expect(input logic [9:0] v, input logic lj);
    return lj ? 16'(v) * 16'd64 : 16'(v);
  endfunction

  task automatic run_conv(input int acq, input logic [9:0] v, input logic lj,
                          input int tad_per, input bit poke);
    int acq_n = 0, conv_n = 0, it = 0;
    bit first_seen = 0, poked = 0, ended = 0;
    @(negedge clk);
    acq_sel = 3'(acq); vin = v; left_just = lj; go_set = 1'b1; tad_en = 1'b0;
    while (!ended && it < 400) begin
      @(negedge clk);
      go_set = 1'b0;
      if (poke && it == 3 && !poked) begin go_set = 1'b1; acq_sel = 3'd7; poked = 1; end
      tad_en = ((tick % tad_per) == 0);
      tick++;
      chan_sel = 5'(it * 7 + acq);
      #1;
      check(chan_mux == chan_sel, "R9 chan follows", chan_mux, chan_sel);
      if (it == 0) begin
        check(go_busy == 1'b1, "R11 busy after go", go_busy, 1);
        if (acq == 0) check(sample_en == 1'b0, "R2 manual stops sampling", sample_en, 0);
        else          check(sample_en == 1'b1, "R3 auto keeps sampling", sample_en, 1);
      end
      if (!go_busy) ended = 1;
      else if (sample_en) begin
        if (tad_en) acq_n++;
      end else begin
        if (!first_seen) begin
          check(trial_code == 10'h200, "R4 MSB first trial", trial_code, 'h200);
          first_seen = 1;
        end
        if (tad_en) conv_n++;
      end
      it++;
    end
    go_set = 1'b0; tad_en = 1'b0;
    if (poke) begin
      check(acq_n == acq_expect(acq), "R7 acq unchanged by go", acq_n, acq_expect(acq));
      check(result == fmt_expect(v, lj), "R7 result unchanged by go", result, fmt_expect(v, lj));
    end
    if (acq == 0) check(acq_n == 0, "R2 no acquisition", acq_n, 0);
    else check(acq_n == acq_expect(acq), "R3 acquisition length", acq_n, acq_expect(acq));
    check(conv_n == 10, "R4 ten decisions", conv_n, 10);
    check(result == fmt_expect(v, lj), "R8 justified result", result, fmt_expect(v, lj));
    check(irq_flag == 1'b1, "R5 irq on done", irq_flag, 1);
    check(sample_en == 1'b1, "R5 sampling resumes", sample_en, 1);
    check(trial_code == 10'd0, "R4 trial idle", trial_code, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [9:0]  pat [8];
    pat = '{10'h000, 10'h001, 10'h3FF, 10'h200, 10'h1FF, 10'h155, 10'h2AA, 10'h0C3};
    repeat (3) @(negedge clk);
    #1;
    check(go_busy == 1'b0 && irq_flag == 1'b0, "R1 reset status", {go_busy, irq_flag}, 0);
    check(result == 16'd0, "R1 reset result", result, 0);
    check(sample_en == 1'b1 && trial_code == 10'd0, "R1 reset sampling", sample_en, 1);
    @(negedge clk); rst_n = 1'b1;

    // R10 reference decode sweep
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        @(negedge clk); pref_sel = 2'(p); nref_sel = 2'(n); #1;
        check(pref_mux == ((p == 1) ? 3'b010 : (p == 2) ? 3'b100 : 3'b001),
              "R10 positive ref", pref_mux, p);
        check(nref_mux == ((n == 1) ? 2'b10 : 2'b01), "R10 negative ref", nref_mux, n);
      end
    end
    // R9 idle channel sweep
    for (int c = 0; c < 32; c++) begin
      @(negedge clk); chan_sel = 5'(c); #1;
      check(chan_mux == 5'(c), "R9 idle chan", chan_mux, c);
    end

    // Main sweep: all acquisition codes, several levels, three TAD cadences
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 8; k++) begin
        run_conv(a, pat[k] ^ 10'(a * 37), 1'((k + a) % 2), 1 + ((a + k) % 3), (k == 5));
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0; #1;
        check(irq_flag == 1'b0, "R6 irq cleared", irq_flag, 0);
      end
    end

    // R6 sticky flag and R8 result hold between conversions
    run_conv(4, 10'h2C7, 1'b1, 2, 1'b0);
    held = result;
    repeat (6) begin
      @(negedge clk); left_just = ~left_just; vin = vin + 10'd91; #1;
      check(irq_flag == 1'b1, "R6 irq sticky", irq_flag, 1);
      check(result == held, "R8 result held", result, held);
    end
    // Start with flag still set: it remains set through the next cycle
    run_conv(0, 10'h013, 1'b0, 1, 1'b0);
    check(result == 16'h0013, "R8 right justified", result, 'h13);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule